// File: doc/BRIEF.md
# Mixed-Depth Pixel Source Selector

This block turns three parallel per-pixel inputs into one 24-bit RGB output pixel per clock. The inputs are an 8-bit colour index, a 32-bit true-colour word and a 32-bit per-pixel mode word. The mode word decides, pixel by pixel, whether the output is taken from the true-colour word or from the palette entry that the index selects. Palette and true-colour pixels can therefore sit next to each other on the same line.

Both 32-bit words arrive in memory byte order, which is most-significant byte first. The block reverses their bytes before it tests the mode tag or extracts the colour. Palette lookups go out on a request port and come back on a response port after a fixed number of cycles, `PAL_LAT`. The true-colour path and the pixel's mode are delayed by the same number of cycles, so both sources meet in step at a registered output mux. Video timing and memory fetch sit outside the block.

Top module: `pixel_source_select`

## Requirements
- R1: When the byte-swapped mode word has 0x03 in bits [31:24] (raw `inCtrl[7:0]` == 0x03), the pixel is a direct pixel and its output comes from the true-colour word. Any other value in `inCtrl[31:8]` does not affect this decision.
- R2: A direct pixel's output is bits [23:0] of the byte-swapped true-colour word, with red in [23:16], green in [15:8] and blue in [7:0]. In raw terms, red is `inDirect[15:8]`, green is `inDirect[23:16]` and blue is `inDirect[31:24]`.
- R3: When `inCtrl[7:0]` is anything other than 0x03, the output is the palette colour returned for that pixel's `inIndex`.
- R4: A palette request (`palReqValid` high, with `palReqIndex` equal to `inIndex`) is raised in the same cycle as an accepted palette pixel. No request is raised for a direct pixel or for an idle cycle.
- R5: Bits [7:0] of the raw true-colour word are the top byte after the swap, and they never change the output.
- R6: Every accepted pixel appears on `outValid`/`outPixel` exactly `PAL_LAT`+1 cycles after the cycle it was presented. Pixels keep their input order, and back-to-back inputs give back-to-back outputs with no bubbles.
- R7: While `outValid` is low, `outPixel` is all zeros. During and directly after reset, `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel present this cycle |
| inIndex | input | 8 | Palette index of the pixel |
| inDirect | input | 32 | True-colour word, memory byte order |
| inCtrl | input | 32 | Per-pixel mode word, memory byte order |
| palReqValid | output | 1 | Palette lookup request |
| palReqIndex | output | 8 | Palette entry to read |
| palRspValid | input | 1 | Palette response present (PAL_LAT cycles after request) |
| palRspColor | input | 24 | Palette colour, R in [23:16], G in [15:8], B in [7:0] |
| outValid | output | 1 | Output pixel present |
| outPixel | output | 24 | Output RGB pixel, zero when not valid |

## Verification
A palette reference with distinct red, green and blue per index answers requests after the fixed latency. Runs of direct pixels and runs of palette pixels are mixed with alternating direct/palette streams, so a swapped mux select or a mode bit that travels with the wrong pixel shows up at once. Tags of 0x02, 0x83 and 0x03 placed in the wrong byte of the mode word separate a correct tag decode from a partial or unswapped one. True-colour words whose three colour bytes all differ expose any wrong byte order, and varying the ignored byte checks that it has no effect. Gapped and back-to-back streams, each tagged with its input cycle, confirm the fixed latency, the absence of bubbles and the zero output on idle cycles.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;

  // Strobes from control to datapath at the final delay stage.
  typedef struct packed {
    logic load;       // a pixel leaves the delay line this cycle
    logic useDirect;  // that pixel takes the true-colour path
  } selStrobe_t;

  // Memory holds words most-significant byte first; reverse to native order.
  function automatic logic [31:0] swapBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/pxsel_ctrl.sv
module pxsel_ctrl
  import pxsel_pkg::*;
#(
  parameter int unsigned PAL_LAT    = 2,
  parameter bit          SWAP_BYTES = 1'b1,
  parameter logic [7:0]  DIRECT_TAG = 8'h03
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inIndex,
  input  logic [31:0]      inCtrl,
  input  logic             palRspValid,
  output logic             palReqValid,
  output logic [7:0]       palReqIndex,
  output selStrobe_t       strobe
);

  localparam int unsigned LAST = PAL_LAT - 1;

  logic [31:0] ctrlWord;
  logic        isDirect;

  generate
    if (SWAP_BYTES) begin : g_swap
      assign ctrlWord = swapBytes(inCtrl);
    end else begin : g_native
      assign ctrlWord = inCtrl;
    end
  endgenerate

  assign isDirect    = (ctrlWord[31:24] == DIRECT_TAG);
  assign palReqValid = inValid && !isDirect;
  assign palReqIndex = inIndex;

  logic [PAL_LAT-1:0] validPipe;
  logic [PAL_LAT-1:0] directPipe;

  generate
    for (genvar s = 0; s < PAL_LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rstN) begin
            validPipe[0]  <= 1'b0;
            directPipe[0] <= 1'b0;
          end else begin
            validPipe[0]  <= inValid;
            directPipe[0] <= inValid && isDirect;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rstN) begin
            validPipe[s]  <= 1'b0;
            directPipe[s] <= 1'b0;
          end else begin
            validPipe[s]  <= validPipe[s-1];
            directPipe[s] <= directPipe[s-1];
          end
        end
      end
    end
  endgenerate

  assign strobe.load      = validPipe[LAST];
  assign strobe.useDirect = directPipe[LAST];

  // R3: a palette pixel reaching the mux must find its response present
  p_rsp_present_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.useDirect) |-> palRspValid);

  // R4: a direct mark never travels without a pixel
  p_direct_has_pixel_r4 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.useDirect |-> strobe.load);

endmodule

// File: rtl/pxsel_datapath.sv
module pxsel_datapath
  import pxsel_pkg::*;
#(
  parameter int unsigned PAL_LAT    = 2,
  parameter bit          SWAP_BYTES = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] inDirect,
  input  selStrobe_t  strobe,
  input  logic [23:0] palRspColor,
  output logic        outValid,
  output logic [23:0] outPixel
);

  localparam int unsigned LAST  = PAL_LAT - 1;
  localparam int unsigned RGB_W = 24;

  logic [31:0]      directWord;
  logic [RGB_W-1:0] rgbPipe [PAL_LAT];

  generate
    if (SWAP_BYTES) begin : g_swap
      assign directWord = swapBytes(inDirect);
    end else begin : g_native
      assign directWord = inDirect;
    end
  endgenerate

  generate
    for (genvar s = 0; s < PAL_LAT; s++) begin : g_delay
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rstN) rgbPipe[0] <= '0;
          else       rgbPipe[0] <= directWord[RGB_W-1:0];
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rstN) rgbPipe[s] <= '0;
          else       rgbPipe[s] <= rgbPipe[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPixel <= '0;
    end else begin
      outValid <= strobe.load;
      if (!strobe.load)         outPixel <= '0;
      else if (strobe.useDirect) outPixel <= rgbPipe[LAST];
      else                       outPixel <= palRspColor;
    end
  end

  // R1 / R2: direct pixel takes the delayed true-colour bytes
  p_direct_mux_r1 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.useDirect) |=> (outValid && outPixel == $past(rgbPipe[LAST])));

  // R3: palette pixel takes the response colour
  p_palette_mux_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.useDirect) |=> (outValid && outPixel == $past(palRspColor)));

  // R6: no bubble is inserted after the delay line
  p_no_bubble_r6 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);

  // R7: idle output carries zeros
  p_idle_zero_r7 : assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outPixel == '0));

endmodule

// File: rtl/pixel_source_select.sv
module pixel_source_select
  import pxsel_pkg::*;
#(
  parameter int unsigned PAL_LAT    = 2,
  parameter bit          SWAP_BYTES = 1'b1,
  parameter logic [7:0]  DIRECT_TAG = 8'h03
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inIndex,
  input  logic [31:0] inDirect,
  input  logic [31:0] inCtrl,
  output logic        palReqValid,
  output logic [7:0]  palReqIndex,
  input  logic        palRspValid,
  input  logic [23:0] palRspColor,
  output logic        outValid,
  output logic [23:0] outPixel
);

  selStrobe_t strobe;

  pxsel_ctrl #(
    .PAL_LAT   (PAL_LAT),
    .SWAP_BYTES(SWAP_BYTES),
    .DIRECT_TAG(DIRECT_TAG)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inIndex    (inIndex),
    .inCtrl     (inCtrl),
    .palRspValid(palRspValid),
    .palReqValid(palReqValid),
    .palReqIndex(palReqIndex),
    .strobe     (strobe)
  );

  pxsel_datapath #(
    .PAL_LAT   (PAL_LAT),
    .SWAP_BYTES(SWAP_BYTES)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .inDirect   (inDirect),
    .strobe     (strobe),
    .palRspColor(palRspColor),
    .outValid   (outValid),
    .outPixel   (outPixel)
  );

endmodule

// File: tb/sim_pixel_source_select.sv
`timescale 1ns/1ps
module sim_pixel_source_select;

  localparam int PL  = 2;
  localparam int LAT = PL + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inIndex = '0;
  logic [31:0] inDirect = '0;
  logic [31:0] inCtrl = '0;
  logic        palReqValid;
  logic [7:0]  palReqIndex;
  logic        palRspValid;
  logic [23:0] palRspColor;
  logic        outValid;
  logic [23:0] outPixel;

  always #2.5 clk = ~clk;

  pixel_source_select #(.PAL_LAT(PL)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIndex(inIndex),
    .inDirect(inDirect), .inCtrl(inCtrl),
    .palReqValid(palReqValid), .palReqIndex(palReqIndex),
    .palRspValid(palRspValid), .palRspColor(palRspColor),
    .outValid(outValid), .outPixel(outPixel)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;

  function automatic logic [23:0] palColor(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction

  // Palette reference: response PL cycles after request
  logic       rv [PL];
  logic [7:0] ri [PL];
  always_ff @(posedge clk) begin
    rv[0] <= palReqValid;
    ri[0] <= palReqIndex;
    for (int k = 1; k < PL; k++) begin
      rv[k] <= rv[k-1];
      ri[k] <= ri[k-1];
    end
  end
  assign palRspValid = rv[PL-1];
  assign palRspColor = rv[PL-1] ? palColor(ri[PL-1]) : 24'h0;

  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard
  logic [23:0] expPix [$];
  int          expCyc [$];
  int          expReq [$];
  bit          monOn = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: presents one cycle of input and pushes the expectation
  task automatic drive(input bit v, input logic [7:0] idx,
                       input logic [31:0] dw, input logic [31:0] cw);
    bit isDir;
    @(negedge clk);
    inValid  = v;
    inIndex  = idx;
    inDirect = dw;
    inCtrl   = cw;
    isDir    = (cw[7:0] == 8'h03);            // R1 tag in raw low byte
    if (v) begin
      // R2 byte order: R=raw[15:8], G=raw[23:16], B=raw[31:24]; R3 palette
      expPix.push_back(isDir ? {dw[15:8], dw[23:16], dw[31:24]} : palColor(idx));
      expCyc.push_back(cyc + LAT);
      expReq.push_back(isDir ? 1 : 3);
    end
    #1;
    // R4: request only for valid palette pixels, carrying the index
    check(palReqValid == (v && !isDir), "R4 req", palReqValid, v && !isDir);
    if (v && !isDir) check(palReqIndex == idx, "R4 idx", palReqIndex, idx);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 8'h00, 32'h0, 32'h0);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (expPix.size() == 0) begin
          check(1'b0, "R6 extra pixel", outPixel, 0);
        end else begin
          logic [23:0] ep;
          int ec, er;
          ep = expPix.pop_front();
          ec = expCyc.pop_front();
          er = expReq.pop_front();
          check(outPixel == ep, (er == 1) ? "R1/R2 direct" : "R3 palette", outPixel, ep);
          check(cyc == ec, "R6 latency", cyc, ec);
        end
      end else begin
        check(outPixel == 24'h0, "R7 idle zero", outPixel, 0);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(outValid == 1'b0, "R7 reset valid", outValid, 0);
    check(outPixel == 24'h0, "R7 reset pixel", outPixel, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R7 post-reset valid", outValid, 0);
    monOn = 1'b1;

    // R1/R2: single direct pixel, distinct bytes
    drive(1'b1, 8'h11, 32'hC3B2A1FF, 32'h00000003);
    idle(LAT + 1);
    // R3: single palette pixel
    drive(1'b1, 8'h42, 32'h12345678, 32'h00000000);
    idle(LAT + 1);
    // R1: near-miss tags go to palette
    drive(1'b1, 8'h01, 32'hAABBCC00, 32'h00000002);
    drive(1'b1, 8'h02, 32'hAABBCC00, 32'h00000083);
    drive(1'b1, 8'h03, 32'hAABBCC00, 32'h03000000);
    drive(1'b1, 8'h04, 32'hAABBCC00, 32'h00030000);
    // R1: other mode-word bytes do not matter for a real tag
    drive(1'b1, 8'h05, 32'h33221100, 32'hFFEEDD03);
    idle(LAT + 1);
    // R5: ignored byte varied, same colour
    drive(1'b1, 8'h00, 32'h30201000, 32'h00000003);
    drive(1'b1, 8'h00, 32'h302010FF, 32'h00000003);
    drive(1'b1, 8'h00, 32'h3020105A, 32'h00000003);
    // R6: back-to-back alternating mix, boundary indices
    for (int k = 0; k < 16; k++) begin
      if (k[0]) drive(1'b1, 8'(k * 17), 32'h0, 32'h0);
      else      drive(1'b1, 8'hFF - 8'(k), {8'(k), 8'(k + 1), 8'(k + 2), 8'hEE}, 32'h00000003);
    end
    drive(1'b1, 8'h00, 32'h0, 32'h0);
    drive(1'b1, 8'hFF, 32'h0, 32'h0);
    // R6: gapped stream
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 8'(k + 100), {8'(k * 3), 8'(k * 5), 8'(k * 7), 8'h00}, (k % 3 == 0) ? 32'h3 : 32'h1);
      idle(k % 3);
    end
    // long direct run then long palette run
    for (int k = 0; k < 10; k++) drive(1'b1, 8'h0, {8'(k), 8'hA0, 8'h0F, 8'h00}, 32'h3);
    for (int k = 0; k < 10; k++) drive(1'b1, 8'(200 + k), 32'hFFFFFFFF, 32'h0);
    idle(LAT + 3);
    // R6: nothing lost
    check(expPix.size() == 0, "R6 drained", expPix.size(), 0);
    monOn = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule